// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the fetch address for a small processor whose program memory is split into pages. Each cycle the counter steps to the next instruction. A jump supplies only the low part of the destination; the two top address bits are taken from a page-select latch that software loads beforehand. The execute unit can also request a skip, which cancels the instruction that has already been fetched.

A jump and a taken skip each cost one extra cycle. The block shows this through a one-cycle flush strobe. The strobe tells the pipeline to run the fetched instruction as a no-op. While that no-op is in execution, the sequencer ignores any jump or skip request, because it comes from an instruction that does not really execute. During a skip the counter keeps stepping, so execution resumes at the instruction after the cancelled one.

Top module: `pc_pager`

## Requirements
- R1: After reset `pc_o` is 0 and `flush_o` is 0.
- R2: In a cycle with no accepted jump, `pc_o` increases by exactly one on the next clock edge.
- R3: An accepted jump loads `pc_o[10:0]` from `jump_tgt_i` and `pc_o[12:11]` from `page_latch_i[4:3]`. Bits 2:0 of `page_latch_i` have no effect on the counter.
- R4: An accepted jump sets `flush_o` for exactly the one cycle in which `pc_o` holds the jump destination. After that the counter continues from destination + 1 with `flush_o` low, so the jump takes two cycles.
- R5: An accepted skip (`skip_i` = 1 with `jump_i` = 0) sets `flush_o` for one cycle. The counter steps by one as usual, so the cancelled instruction is passed over and execution resumes after it.
- R6: When `skip_i` and `jump_i` are both 0, `flush_o` is 0 in the following cycle.
- R7: While `flush_o` is 1, `jump_i` and `skip_i` are ignored. The counter steps by one and `flush_o` returns to 0.
- R8: When `jump_i` and `skip_i` are both 1 and accepted, the jump takes priority: `pc_o` loads the jump destination.
- R9: Stepping from 0x1FFF wraps `pc_o` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_i | input | 1 | Unconditional jump request from the executing instruction |
| jump_tgt_i | input | 11 | In-page jump destination |
| page_latch_i | input | 5 | Page-select latch; bits 4:3 give the upper counter bits |
| skip_i | input | 1 | Taken-skip request from the execute unit |
| pc_o | output | 13 | Current program counter (fetch address) |
| flush_o | output | 1 | Run the fetched instruction as a no-op this cycle |

## Verification
The assertions assume that `jump_i` and `skip_i` are single-cycle strobes tied to the instruction that executes in that cycle. They also assume that the page latch and the target are valid whenever a jump is raised; the properties sample them only in that cycle. The bench changes inputs only on falling edges and holds each request for one cycle. On purpose, it also raises requests in the flush cycle, to check that they are ignored there.

// File: rtl/pc_pager.sv
module pc_pager #(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int LATCH_W = 5,
  parameter int PAGE_LO = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               jump_i,
  input  logic [TGT_W-1:0]   jump_tgt_i,
  input  logic [LATCH_W-1:0] page_latch_i,
  input  logic               skip_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               flush_o
);

  localparam int PAGE_W  = PC_W - TGT_W;
  localparam int PAGE_HI = PAGE_LO + PAGE_W - 1;

  logic [PC_W-1:0] pc_q;
  logic            flush_q;
  logic            accept, take_jump, take_skip;
  logic [PC_W-1:0] jump_dest;

  assign accept    = ~flush_q;
  assign take_jump = accept & jump_i;
  assign take_skip = accept & skip_i & ~jump_i;
  assign jump_dest = {page_latch_i[PAGE_HI:PAGE_LO], jump_tgt_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= take_jump ? jump_dest : pc_q + 1'b1;
      flush_q <= take_jump | take_skip;
    end
  end

  assign pc_o    = pc_q;
  assign flush_o = flush_q;

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !flush_o) |=> (pc_o[TGT_W-1:0] == $past(jump_tgt_i)) &&
      (pc_o[PC_W-1:TGT_W] == PAGE_W'($past(page_latch_i) >> PAGE_LO)));

  // R4
  jump_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !flush_o) |=> flush_o);

  // R5
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_i && !jump_i && !flush_o) |=> flush_o && (pc_o == $past(pc_o) + 1'b1));

  // R6
  quiet_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_i && !skip_i) |=> !flush_o);

  // R7
  flush_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o && (pc_o == $past(pc_o) + 1'b1));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_i || flush_o) |=> (pc_o == $past(pc_o) + 1'b1));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&pc_o) && (!jump_i || flush_o)) |=> (pc_o == '0));

endmodule

// File: tb/pc_pager_tb.sv
module pc_pager_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        jump_i;
  logic [10:0] jump_tgt_i;
  logic [4:0]  page_latch_i;
  logic        skip_i;
  logic [12:0] pc_o;
  logic        flush_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pc_pager dut_i (
    .clk(clk), .rst_n(rst_n), .jump_i(jump_i), .jump_tgt_i(jump_tgt_i),
    .page_latch_i(page_latch_i), .skip_i(skip_i), .pc_o(pc_o), .flush_o(flush_o)
  );

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    jump_i = 1'b0; skip_i = 1'b0;
  endtask

  task automatic do_jump(input logic [4:0] latch, input logic [10:0] tgt);
    page_latch_i = latch; jump_tgt_i = tgt; jump_i = 1'b1; skip_i = 1'b0;
    step();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); jump_tgt_i = '0; page_latch_i = '0;
    @(negedge clk); step(); step();
    chk("R1 pc after reset", pc_o, 13'h0);
    chk("R1 flush after reset", {12'h0, flush_o}, 13'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_seq();
    logic [12:0] p;
    p = pc_o;
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R2 sequential step", pc_o, p + 13'(i));
      chk("R6 no flush when quiet", {12'h0, flush_o}, 13'h0);
    end
  endtask

  task automatic t_jump();
    do_jump(5'b10110, 11'h5A5);
    chk("R3 jump dest", pc_o, 13'h15A5);
    chk("R4 flush on jump", {12'h0, flush_o}, 13'h1);
    step();
    chk("R4 resume dest+1", pc_o, 13'h15A6);
    chk("R4 flush one cycle", {12'h0, flush_o}, 13'h0);
  endtask

  task automatic t_latch_low_bits();
    do_jump(5'b01111, 11'h023);
    chk("R3 page from latch bits 4:3, low bits ignored", pc_o, 13'h0823);
    step();
    do_jump(5'b00000, 11'h023);
    chk("R3 page zero", pc_o, 13'h0023);
    step();
  endtask

  task automatic t_skip();
    logic [12:0] p;
    p = pc_o;
    skip_i = 1'b1;
    step();
    idle();
    chk("R5 skip pc steps", pc_o, p + 13'd1);
    chk("R5 skip flush", {12'h0, flush_o}, 13'h1);
    step();
    chk("R5 resume after skipped", pc_o, p + 13'd2);
    chk("R5 flush one cycle", {12'h0, flush_o}, 13'h0);
  endtask

  task automatic t_ignore_in_flush();
    logic [12:0] p;
    do_jump(5'b01000, 11'h100);
    p = pc_o;
    chk("R7 setup jump", p, 13'h0900);
    page_latch_i = 5'b11000; jump_tgt_i = 11'h7AA; jump_i = 1'b1; skip_i = 1'b1;
    step();
    idle();
    chk("R7 jump ignored in flush", pc_o, p + 13'd1);
    chk("R7 flush clears", {12'h0, flush_o}, 13'h0);
  endtask

  task automatic t_jump_beats_skip();
    page_latch_i = 5'b11000; jump_tgt_i = 11'h0F0; jump_i = 1'b1; skip_i = 1'b1;
    step();
    idle();
    chk("R8 jump wins", pc_o, 13'h18F0);
    chk("R8 flush", {12'h0, flush_o}, 13'h1);
    step();
  endtask

  task automatic t_wrap();
    do_jump(5'b11000, 11'h7FF);
    chk("R9 at top", pc_o, 13'h1FFF);
    step();
    chk("R9 wraps to zero", pc_o, 13'h0000);
    step();
    chk("R9 continues", pc_o, 13'h0001);
  endtask

  initial begin
    jump_i = 1'b0; skip_i = 1'b0; jump_tgt_i = '0; page_latch_i = '0; rst_n = 1'b0;
    t_reset();
    t_seq();
    t_jump();
    t_latch_low_bits();
    t_skip();
    t_ignore_in_flush();
    t_jump_beats_skip();
    t_wrap();
    t_seq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule